// File: doc/BRIEF.md
# Shift and Rotate Unit

This block is a barrel shifter with a single register stage, meant for the integer execution path of a processor core. For each request it applies one of five operations: logical right shift, arithmetic right shift, left shift, rotate right or rotate left. The operation works on the low 8, 16 or 32 bits of a 32-bit operand. The result appears one clock after the request. Bits of the operand above the selected size come back unchanged. A flag reports whether the shifted part of the result is zero.

The shift count is five bits wide. It comes either from an immediate field or from the low five bits of a count register, and a select input picks between the two. Every stage of the barrel works with its own fixed width. A count that reaches or passes the operand width therefore empties a shift lane completely, and a rotate wraps inside the selected width.

Top module: `shrot_unit`

## Requirements
- R1: Operation code 0 is a logical right shift, and zeros enter at the most significant bit of the selected width.
- R2: Operation code 1 is an arithmetic right shift: every vacated high bit takes the original sign bit of the selected width (byte 0xBB by 1 gives 0xDD; 0xABBCCDD0 by 2 gives 0xEAEF3374).
- R3: Operation codes 2 and 3 both shift left, give identical results, and let zeros in at bit 0 (0xAABBCCDD by 4 gives 0xABBCCDD0).
- R4: Operation code 4 rotates right and code 5 rotates left inside the selected width (byte 0xBA gives 0x5D right by 1 and 0x75 left by 1; 0xEAEF3374 left by 4 gives 0xAEF3374E).
- R5: With `cnt_from_reg` at 1 the count is `cnt_reg[4:0]`; with 0 the count is `cnt_imm`. Bits 7:5 of `cnt_reg` have no effect.
- R6: A shift whose count is at least the selected width leaves only fill bits in that width: zeros for codes 0, 2 and 3, and copies of the sign bit for code 1.
- R7: A rotate by count c gives the same result as a rotate by c modulo the selected width.
- R8: A count of zero returns the operand unchanged for every operation and size.
- R9: Size code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Result bits above the selected width equal the operand bits.
- R10: `result_zero` is 1 exactly when the selected-width part of `result` is zero.
- R11: `result`, `result_zero` and `out_valid` are registered. A request sampled with `in_valid` appears after one clock edge. With `in_valid` low, `out_valid` drops and `result` holds. Reset clears all three. Operation codes 6 and 7 return the operand unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op_code | input | 3 | Operation select (see R1 to R4, R11) |
| op_size | input | 2 | Operand size select (see R9) |
| operand | input | 32 | Value to shift or rotate |
| cnt_imm | input | 5 | Immediate count |
| cnt_reg | input | 8 | Count register value; only bits 4:0 are used |
| cnt_from_reg | input | 1 | 1 takes the count from `cnt_reg`, 0 from `cnt_imm` |
| out_valid | output | 1 | Result registered from a request |
| result | output | 32 | Shifted or rotated value |
| result_zero | output | 1 | Selected-width part of `result` is zero |

## Verification
The assertions assume that every input is driven to a known value whenever `in_valid` is high. They also assume that `out_valid` high means the previous cycle carried a request, so the checker keeps its own registered copy of the size to judge the zero flag. The bench changes inputs only on falling edges and returns `in_valid` to low between requests. This keeps every property's antecedent tied to one sampled request. The bench also uses only size and count values whose meaning the requirements define, including the unused operation codes and count register values with the upper bits set.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    localparam int DATA_W  = 32;
    localparam int CNT_W   = 5;
    localparam int CREG_W  = 8;
    localparam int MIN_W   = 8;
    localparam int N_LANES = $clog2(DATA_W / MIN_W) + 1;
    localparam int SZ_W    = 2;
    localparam int OPC_W   = 3;

    typedef enum logic [2:0] {
        K_SHR  = 3'd0,
        K_SAR  = 3'd1,
        K_SHL  = 3'd2,
        K_ROR  = 3'd3,
        K_ROL  = 3'd4,
        K_PASS = 3'd5
    } shrot_kind_e;

    typedef struct packed {
        shrot_kind_e          kind;
        logic [SZ_W-1:0]      lane_idx;
        logic [CNT_W-1:0]     cnt;
        logic [DATA_W-1:0]    opnd;
    } shrot_req_t;

    function automatic shrot_kind_e decode_kind(input logic [OPC_W-1:0] code);
        case (code)
            3'd0:       return K_SHR;
            3'd1:       return K_SAR;
            3'd2, 3'd3: return K_SHL;
            3'd4:       return K_ROR;
            3'd5:       return K_ROL;
            default:    return K_PASS;
        endcase
    endfunction

    function automatic logic [SZ_W-1:0] size_to_lane(input logic [SZ_W-1:0] sz);
        logic [SZ_W-1:0] top_idx;
        top_idx = SZ_W'(N_LANES - 1);
        return (sz > top_idx) ? top_idx : sz;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input logic [SZ_W-1:0] idx);
        int unsigned w;
        w = MIN_W << idx;
        return {DATA_W{1'b1}} >> (DATA_W - w);
    endfunction

endpackage

// File: rtl/shrot_decode.sv
module shrot_decode
    import shrot_pkg::*;
(
    input  logic [OPC_W-1:0]  op_code,
    input  logic [SZ_W-1:0]   op_size,
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  cnt_imm,
    input  logic [CREG_W-1:0] cnt_reg,
    input  logic              cnt_from_reg,
    output shrot_req_t        req
);

    logic [CNT_W-1:0] reg_cnt_low;

    assign reg_cnt_low = cnt_reg[CNT_W-1:0];

    always_comb begin
        req.kind     = decode_kind(op_code);
        req.lane_idx = size_to_lane(op_size);
        req.cnt      = cnt_from_reg ? reg_cnt_low : cnt_imm;
        req.opnd     = operand;
    end

endmodule

// File: rtl/shrot_lane.sv
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  shrot_kind_e       kind,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout
);

    logic [LANE_W-1:0] stage [CNT_W+1];

    assign stage[0] = din;

    for (genvar k = 0; k < CNT_W; k++) begin : g_stage
        localparam int AMT = 1 << k;
        logic [LANE_W-1:0] moved;

        if (AMT < LANE_W) begin : g_part
            always_comb begin
                case (kind)
                    K_SHR:   moved = {{AMT{1'b0}}, stage[k][LANE_W-1:AMT]};
                    K_SAR:   moved = {{AMT{stage[k][LANE_W-1]}}, stage[k][LANE_W-1:AMT]};
                    K_SHL:   moved = {stage[k][LANE_W-1-AMT:0], {AMT{1'b0}}};
                    K_ROR:   moved = {stage[k][AMT-1:0], stage[k][LANE_W-1:AMT]};
                    K_ROL:   moved = {stage[k][LANE_W-1-AMT:0], stage[k][LANE_W-1:LANE_W-AMT]};
                    default: moved = stage[k];
                endcase
            end
        end else begin : g_full
            always_comb begin
                case (kind)
                    K_SHR, K_SHL: moved = '0;
                    K_SAR:        moved = {LANE_W{stage[k][LANE_W-1]}};
                    default:      moved = stage[k];
                endcase
            end
        end

        assign stage[k+1] = cnt[k] ? moved : stage[k];
    end

    assign dout = stage[CNT_W];

endmodule

// File: rtl/shrot_merge.sv
module shrot_merge
    import shrot_pkg::*;
(
    input  logic [N_LANES-1:0][DATA_W-1:0] lanes,
    input  logic [SZ_W-1:0]                lane_idx,
    input  logic [DATA_W-1:0]              opnd,
    output logic [DATA_W-1:0]              res,
    output logic                           zero
);

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] picked;

    always_comb begin
        mask   = lane_mask(lane_idx);
        picked = lanes[lane_idx] & mask;
        res    = picked | (opnd & ~mask);
        zero   = (picked == '0);
    end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op_code,
    input  logic [1:0]        op_size,
    input  logic [31:0]       operand,
    input  logic [4:0]        cnt_imm,
    input  logic [7:0]        cnt_reg,
    input  logic              cnt_from_reg,
    output logic              out_valid,
    output logic [31:0]       result,
    output logic              result_zero
);

    shrot_req_t                     req;
    logic [N_LANES-1:0][DATA_W-1:0] lane_out;
    logic [DATA_W-1:0]              merged;
    logic                           merged_zero;

    shrot_decode u_decode (
        .op_code      (op_code),
        .op_size      (op_size),
        .operand      (operand),
        .cnt_imm      (cnt_imm),
        .cnt_reg      (cnt_reg),
        .cnt_from_reg (cnt_from_reg),
        .req          (req)
    );

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        localparam int LW = MIN_W << i;
        logic [LW-1:0] lane_res;

        shrot_lane #(.LANE_W(LW)) u_lane (
            .kind (req.kind),
            .cnt  (req.cnt),
            .din  (req.opnd[LW-1:0]),
            .dout (lane_res)
        );

        if (LW < DATA_W) begin : g_pad
            assign lane_out[i] = {{(DATA_W-LW){1'b0}}, lane_res};
        end else begin : g_nopad
            assign lane_out[i] = lane_res;
        end
    end

    shrot_merge u_merge (
        .lanes    (lane_out),
        .lane_idx (req.lane_idx),
        .opnd     (req.opnd),
        .res      (merged),
        .zero     (merged_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            result      <= '0;
            result_zero <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result      <= merged;
                result_zero <= merged_zero;
            end
        end
    end

endmodule

// File: rtl/shrot_check.sv
module shrot_check (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [2:0]  op_code,
    input logic [1:0]  op_size,
    input logic [31:0] operand,
    input logic [4:0]  cnt_imm,
    input logic [7:0]  cnt_reg,
    input logic        cnt_from_reg,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        result_zero
);

    logic [4:0]  eff_cnt;
    logic [1:0]  size_q;
    logic [31:0] zmask;
    logic        is_rot;
    logic        is_left;

    assign eff_cnt = cnt_from_reg ? cnt_reg[4:0] : cnt_imm;
    assign is_rot  = (op_code == 3'd4) || (op_code == 3'd5);
    assign is_left = (op_code == 3'd2) || (op_code == 3'd3);

    always_ff @(posedge clk) begin
        if (rst) size_q <= 2'd0;
        else if (in_valid) size_q <= op_size;
    end

    assign zmask = (size_q == 2'd0) ? 32'h0000_00FF :
                   (size_q == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;

    a_r11_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r11_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r11_hold_result: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    a_r9_upper_byte: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_size == 2'd0) |=> result[31:8] == $past(operand[31:8]));

    a_r9_upper_word: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_size == 2'd1) |=> result[31:16] == $past(operand[31:16]));

    a_r8_zero_count: assert property (@(posedge clk) disable iff (rst)
        (in_valid && eff_cnt == 5'd0) |=> result == $past(operand));

    a_r7_rotate_wrap: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_rot && op_size == 2'd0 && eff_cnt[2:0] == 3'd0)
        |=> result == $past(operand));

    a_r6_left_flush: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_left && op_size == 2'd0 && eff_cnt >= 5'd8)
        |=> result[7:0] == 8'h00);

    a_r10_zero_flag: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (result_zero == ((result & zmask) == 32'h0)));

endmodule

bind shrot_unit shrot_check u_chk (.*);

// File: tb/shrot_unit_bench.sv
`timescale 1ns/1ps
module shrot_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op_code;
    logic [1:0]  op_size;
    logic [31:0] operand;
    logic [4:0]  cnt_imm;
    logic [7:0]  cnt_reg;
    logic        cnt_from_reg;
    logic        out_valid;
    logic [31:0] result;
    logic        result_zero;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    shrot_unit u_shrot_unit (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .op_code      (op_code),
        .op_size      (op_size),
        .operand      (operand),
        .cnt_imm      (cnt_imm),
        .cnt_reg      (cnt_reg),
        .cnt_from_reg (cnt_from_reg),
        .out_valid    (out_valid),
        .result       (result),
        .result_zero  (result_zero)
    );

    function automatic logic [31:0] width_mask(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'h0000_00FF : (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    // Independent model: one bit position per step, count times.
    function automatic logic [31:0] model(input logic [2:0] op, input logic [1:0] sz,
                                          input logic [31:0] a, input logic [4:0] c);
        int          w;
        logic [31:0] m;
        logic [31:0] v;
        w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        m = width_mask(sz);
        v = a & m;
        for (int i = 0; i < int'(c); i++) begin
            case (op)
                3'd0:       v = v >> 1;
                3'd1:       v = (v >> 1) | ({31'b0, v[w-1]} << (w-1));
                3'd2, 3'd3: v = (v << 1) & m;
                3'd4:       v = (v >> 1) | ({31'b0, v[0]} << (w-1));
                3'd5:       v = ((v << 1) & m) | {31'b0, v[w-1]};
                default:    v = v;
            endcase
        end
        return (a & ~m) | v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [2:0] op, input logic [1:0] sz,
                          input logic [31:0] a, input logic [4:0] imm, input logic [7:0] creg,
                          input logic sel, input logic [31:0] exp);
        logic exp_zero;
        @(negedge clk);
        in_valid     = 1'b1;
        op_code      = op;
        op_size      = sz;
        operand      = a;
        cnt_imm      = imm;
        cnt_reg      = creg;
        cnt_from_reg = sel;
        @(negedge clk);
        in_valid = 1'b0;
        exp_zero = ((exp & width_mask(sz)) == 32'h0);
        check(tag, {result_zero, out_valid, 30'b0} == {exp_zero, 1'b1, 30'b0} ? result : ~exp, exp);
    endtask

    task automatic t_reset;
        check("R11 reset result", result, 32'h0);
        check("R11 reset flags", {30'b0, out_valid, result_zero}, 32'h0);
    endtask

    task automatic t_worked_chain;
        run_op("R3 left by 4", 3'd2, 2'd2, 32'hAABBCCDD, 5'd4, 8'h00, 1'b0, 32'hABBCCDD0);
        run_op("R2 arith right by 2", 3'd1, 2'd2, 32'hABBCCDD0, 5'd2, 8'h00, 1'b0, 32'hEAEF3374);
        run_op("R4 rotate left by 4", 3'd5, 2'd2, 32'hEAEF3374, 5'd4, 8'h00, 1'b0, 32'hAEF3374E);
    endtask

    task automatic t_byte_patterns;
        run_op("R4 byte rotate right", 3'd4, 2'd0, 32'h112233BA, 5'd1, 8'h00, 1'b0, 32'h1122335D);
        run_op("R4 byte rotate left", 3'd5, 2'd0, 32'h112233BA, 5'd1, 8'h00, 1'b0, 32'h11223375);
        run_op("R2 byte arith right", 3'd1, 2'd0, 32'h000000BB, 5'd1, 8'h00, 1'b0, 32'h000000DD);
        run_op("R1 byte logical right", 3'd0, 2'd0, 32'hFFFFFFBB, 5'd1, 8'h00, 1'b0, 32'hFFFFFF5D);
        run_op("R1 word logical right", 3'd0, 2'd1, 32'h8000F000, 5'd4, 8'h00, 1'b0, 32'h80000F00);
    endtask

    task automatic t_sal_alias;
        run_op("R3 code 3 byte", 3'd3, 2'd0, 32'h0000005B, 5'd1, 8'h00, 1'b0, 32'h000000B6);
        run_op("R3 code 3 long", 3'd3, 2'd2, 32'hAABBCCDD, 5'd4, 8'h00, 1'b0, 32'hABBCCDD0);
    endtask

    task automatic t_count_source;
        run_op("R5 count reg upper bits ignored", 3'd2, 2'd2, 32'h00000001, 5'd0, 8'hE4, 1'b1, 32'h00000010);
        run_op("R5 immediate chosen", 3'd2, 2'd2, 32'h00000001, 5'd3, 8'hFF, 1'b0, 32'h00000008);
        run_op("R5 reg 0x20 acts as zero", 3'd0, 2'd2, 32'hF0F0F0F0, 5'd7, 8'h20, 1'b1, 32'hF0F0F0F0);
    endtask

    task automatic t_large_counts;
        run_op("R6 byte shr past width", 3'd0, 2'd0, 32'h00000080, 5'd9, 8'h00, 1'b0, 32'h00000000);
        run_op("R6 byte sar past width", 3'd1, 2'd0, 32'h00000080, 5'd20, 8'h00, 1'b0, 32'h000000FF);
        run_op("R6 word shl at width", 3'd2, 2'd1, 32'hABCDFFFF, 5'd16, 8'h00, 1'b0, 32'hABCD0000);
        run_op("R6 long shr by 31", 3'd0, 2'd2, 32'h80000000, 5'd31, 8'h00, 1'b0, 32'h00000001);
        run_op("R6 word sar positive", 3'd1, 2'd1, 32'h00007FFF, 5'd31, 8'h00, 1'b0, 32'h00000000);
    endtask

    task automatic t_rotate_mod;
        run_op("R7 byte rol by 9", 3'd5, 2'd0, 32'h000000BA, 5'd9, 8'h00, 1'b0, 32'h00000075);
        run_op("R7 word ror by 20", 3'd4, 2'd1, 32'h00001234, 5'd20, 8'h00, 1'b0, 32'h00004123);
        run_op("R7 byte ror by 8", 3'd4, 2'd0, 32'h55AA3C96, 5'd8, 8'h00, 1'b0, 32'h55AA3C96);
    endtask

    task automatic t_zero_count;
        for (int op = 0; op < 6; op++) begin
            run_op("R8 count zero", 3'(op), 2'(op % 3), 32'hDEADBEEF, 5'd0, 8'hE0, 1'b1, 32'hDEADBEEF);
        end
    endtask

    task automatic t_upper_pass;
        run_op("R9 size 3 acts as long", 3'd0, 2'd3, 32'hF0000000, 5'd4, 8'h00, 1'b0, 32'h0F000000);
        run_op("R9 word upper kept", 3'd5, 2'd1, 32'hCAFE8001, 5'd1, 8'h00, 1'b0, 32'hCAFE0003);
    endtask

    task automatic t_zero_flag;
        run_op("R10 zero lane with upper set", 3'd2, 2'd0, 32'hFFFFFF80, 5'd1, 8'h00, 1'b0, 32'hFFFFFF00);
        run_op("R10 nonzero lane", 3'd0, 2'd2, 32'h00000002, 5'd1, 8'h00, 1'b0, 32'h00000001);
    endtask

    task automatic t_unused_codes_and_hold;
        run_op("R11 code 6 passes", 3'd6, 2'd2, 32'h13579BDF, 5'd5, 8'h00, 1'b0, 32'h13579BDF);
        run_op("R11 code 7 passes", 3'd7, 2'd0, 32'h2468ACE0, 5'd3, 8'h00, 1'b0, 32'h2468ACE0);
        @(negedge clk);
        operand = 32'h0;
        @(negedge clk);
        check("R11 idle holds result", result, 32'h2468ACE0);
        check("R11 idle drops valid", {31'b0, out_valid}, 32'h0);
    endtask

    task automatic t_sweep;
        logic [4:0] cnts [4];
        cnts[0] = 5'd1; cnts[1] = 5'd7; cnts[2] = 5'd13; cnts[3] = 5'd31;
        for (int op = 0; op < 6; op++) begin
            for (int sz = 0; sz < 3; sz++) begin
                for (int ci = 0; ci < 4; ci++) begin
                    run_op("R1 R2 R3 R4 sweep", 3'(op), 2'(sz), 32'h9C3AE571, cnts[ci], 8'h00, 1'b0,
                           model(3'(op), 2'(sz), 32'h9C3AE571, cnts[ci]));
                end
            end
        end
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_code = '0; op_size = '0; operand = '0;
        cnt_imm = '0; cnt_reg = '0; cnt_from_reg = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_worked_chain;
        t_byte_patterns;
        t_sal_alias;
        t_count_source;
        t_large_counts;
        t_rotate_mod;
        t_zero_count;
        t_upper_pass;
        t_zero_flag;
        t_unused_codes_and_hold;
        t_sweep;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule